// File: doc/BRIEF.md
# Asynchronous Memory Strobe Sequencer with Ready Stretch

This block drives the active-low read and write strobes of one external asynchronous memory bank. A request enters through a valid/ready port. The block holds the address and write data on the memory pins and asserts the chosen strobe. It counts down a programmed number of access cycles. It can then wait for the memory's ready pin before it releases the strobe. It ends each access by returning a one-cycle response that carries read data and an error flag. It then enforces a programmable idle gap before the next request is accepted.

The ready pin is asynchronous. It passes through a two-stage synchronizer and is interpreted with a per-bank polarity. A watchdog of 64 cycles can be enabled. It starts when the programmed access time runs out, and it ends the access with an error if ready never shows up. The bank settings (access cycles, gap cycles, ready enable, ready polarity, abort enable) are taken from the configuration inputs when a request is accepted. They stay fixed for the whole access and the gap that follows it.

Request back-pressure: `req_ready` is high only while the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The requester must hold its fields stable in that cycle. The response side has no back-pressure: `rsp_valid` is a single-cycle pulse that the requester must catch.

Top module: `amseq_top`

## Requirements
- R1: Out of reset, `mem_re_n` and `mem_we_n` are high, `req_ready` is high and `rsp_valid` is low.
- R2: `req_ready` is high only while idle. An accepted request with `req_write`=1 drives only `mem_we_n` low, and one with `req_write`=0 drives only `mem_re_n` low. `mem_addr` and `mem_wdata` carry the accepted values while the strobe is low.
- R3: With ready sampling disabled, the strobe stays low for exactly max(`cfg_access`,1) cycles, whatever the level of `mem_rdy`.
- R4: With ready sampling enabled, `mem_rdy` is considered only after the access count expires. If it is already active, a read strobe stays low for max(`cfg_access`,1)+2 cycles. A read strobe rises at most 5 cycles after `mem_rdy` becomes active at the pin.
- R5: With ready sampling enabled, the write strobe rises two cycles after the synchronized ready is seen active. If ready is already active, a write strobe stays low for max(`cfg_access`,1)+3 cycles.
- R6: `cfg_rdy_pol`=1 makes a high `mem_rdy` active; `cfg_rdy_pol`=0 makes a low `mem_rdy` active.
- R7: With abort enabled and ready never active, the strobe stays low for max(`cfg_access`,1)+64 cycles, and the response has `rsp_err`=1.
- R8: With abort disabled, the block waits for ready with no limit, and the response has `rsp_err`=0.
- R9: After each response, `req_ready` stays low for exactly `cfg_turn` cycles. A value of 0 makes the block ready again in the response cycle.
- R10: Read data is captured from `mem_rdata` on the edge where the read strobe rises, and it is presented on `rsp_rdata` with the response.
- R11: Each accepted request gives exactly one single-cycle `rsp_valid` pulse, in the cycle right after its strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| cfg_access | input | CNT_W | Access cycles (0 treated as 1) |
| cfg_turn | input | CNT_W | Idle gap cycles after each access |
| cfg_rdy_en | input | 1 | Enable waiting on ready |
| cfg_rdy_pol | input | 1 | Active level of ready |
| cfg_abort_en | input | 1 | Enable 64-cycle ready watchdog |
| mem_addr | output | ADDR_W | Address to memory |
| mem_wdata | output | DATA_W | Write data to memory |
| mem_rdata | input | DATA_W | Read data from memory |
| mem_re_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_rdy | input | 1 | Asynchronous ready from memory |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Access ended by watchdog |
| rsp_rdata | output | DATA_W | Captured read data |

## Verification
The assertions assume the requester holds the request fields stable while `req_valid` is high. They also assume the configuration inputs do not matter outside acceptance, since the block latches them. They further assume that `mem_rdy` settles at least two cycles before the access count expires whenever an exact strobe length is expected. The stimulus follows these rules as follows. It sets the configuration and the ready pin level, and waits three cycles before raising `req_valid`. It drops `req_valid` right after acceptance. It changes `mem_rdy` during an access only in the directed cases, where the access is already waiting on ready.

// File: rtl/amseq_pkg.sv
package amseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACCESS,
    ST_WAIT,
    ST_RELEASE,
    ST_TURN
  } amseq_state_t;
endpackage

// File: rtl/amseq_sync.sv
module amseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh <= '0;
        else        sh <= din;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], din};
    end
  endgenerate

  assign dout = sh[STAGES-1];
endmodule

// File: rtl/amseq_cnt.sv
module amseq_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         last
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= cnt - 1'b1;

  assign last = (cnt <= W'(1));

  // counting below zero would corrupt access length (R3)
  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |-> (cnt != '0));
endmodule

// File: rtl/amseq_top.sv
module amseq_top
  import amseq_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 16,
  parameter int CNT_W        = 8,
  parameter int ABORT_CYCLES = 64,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [CNT_W-1:0]  cfg_access,
  input  logic [CNT_W-1:0]  cfg_turn,
  input  logic              cfg_rdy_en,
  input  logic              cfg_rdy_pol,
  input  logic              cfg_abort_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_re_n,
  output logic              mem_we_n,
  input  logic              mem_rdy,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam int AB_W = $clog2(ABORT_CYCLES + 1);
  localparam logic [CNT_W-1:0] REL_RD = CNT_W'(1);
  localparam logic [CNT_W-1:0] REL_WR = CNT_W'(2);

  amseq_state_t st, st_nx;
  logic wr_q, ren_q, pol_q, abt_q;
  logic [CNT_W-1:0] turn_q;
  logic rdy_s, rdy_act, accept, end_evt, end_err;
  logic cnt_load, cnt_dec, cnt_last;
  logic [CNT_W-1:0] cnt_val;
  logic ab_load, ab_dec, ab_last;

  amseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(mem_rdy), .dout(rdy_s));

  amseq_cnt #(.W(CNT_W)) u_main_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val),
    .dec(cnt_dec), .last(cnt_last));

  amseq_cnt #(.W(AB_W)) u_abort_cnt (
    .clk(clk), .rst_n(rst_n), .load(ab_load),
    .load_val(AB_W'(ABORT_CYCLES)), .dec(ab_dec), .last(ab_last));

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign rdy_act   = (rdy_s == pol_q);

  always_comb begin
    st_nx    = st;
    end_evt  = 1'b0;
    end_err  = 1'b0;
    cnt_load = 1'b0;
    cnt_val  = '0;
    cnt_dec  = 1'b0;
    ab_load  = 1'b0;
    ab_dec   = 1'b0;
    case (st)
      ST_IDLE: if (accept) begin
        st_nx    = ST_ACCESS;
        cnt_load = 1'b1;
        cnt_val  = (cfg_access == '0) ? CNT_W'(1) : cfg_access;
      end
      ST_ACCESS: begin
        if (cnt_last) begin
          if (ren_q) begin
            st_nx   = ST_WAIT;
            ab_load = 1'b1;
          end else begin
            end_evt = 1'b1;
          end
        end else begin
          cnt_dec = 1'b1;
        end
      end
      ST_WAIT: begin
        if (rdy_act) begin
          st_nx    = ST_RELEASE;
          cnt_load = 1'b1;
          cnt_val  = wr_q ? REL_WR : REL_RD;
        end else if (abt_q && ab_last) begin
          end_evt = 1'b1;
          end_err = 1'b1;
        end else if (abt_q) begin
          ab_dec = 1'b1;
        end
      end
      ST_RELEASE: begin
        if (cnt_last) end_evt = 1'b1;
        else          cnt_dec = 1'b1;
      end
      ST_TURN: begin
        if (cnt_last) st_nx   = ST_IDLE;
        else          cnt_dec = 1'b1;
      end
      default: st_nx = ST_IDLE;
    endcase
    if (end_evt) begin
      if (turn_q != '0) begin
        st_nx    = ST_TURN;
        cnt_load = 1'b1;
        cnt_val  = turn_q;
      end else begin
        st_nx = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      wr_q      <= 1'b0;
      ren_q     <= 1'b0;
      pol_q     <= 1'b1;
      abt_q     <= 1'b0;
      turn_q    <= CNT_W'(2);
      mem_addr  <= '0;
      mem_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      st        <= st_nx;
      rsp_valid <= end_evt;
      rsp_err   <= end_err;
      if (accept) begin
        wr_q      <= req_write;
        ren_q     <= cfg_rdy_en;
        pol_q     <= cfg_rdy_pol;
        abt_q     <= cfg_abort_en;
        turn_q    <= cfg_turn;
        mem_addr  <= req_addr;
        mem_wdata <= req_wdata;
      end
      if (end_evt && !wr_q) rsp_rdata <= mem_rdata;
    end
  end

  logic strobe_on;
  assign strobe_on = (st == ST_ACCESS) || (st == ST_WAIT) || (st == ST_RELEASE);
  assign mem_re_n  = !(strobe_on && !wr_q);
  assign mem_we_n  = !(strobe_on && wr_q);

  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_re_n && !mem_we_n));
  p_busy_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_re_n || !mem_we_n) |-> !req_ready);
  p_wait_needs_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT) |-> ren_q);
  p_err_needs_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (abt_q && rsp_valid));
  p_resp_after_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_re_n) || $rose(mem_we_n)) |-> rsp_valid);
  p_resp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: tb/tb_amseq_top.sv
module tb_amseq_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 8;
  localparam int NVEC   = 8;
  // {wr, access[8], turn[8], rdy_en, pol, abort_en, pin_active, exp_low[8], exp_err}
  localparam logic [29:0] VEC [NVEC] = '{
    {1'b0, 8'd3, 8'd2, 1'b0, 1'b1, 1'b0, 1'b0, 8'd3,  1'b0},
    {1'b1, 8'd1, 8'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd1,  1'b0},
    {1'b0, 8'd0, 8'd1, 1'b0, 1'b1, 1'b0, 1'b0, 8'd1,  1'b0},
    {1'b0, 8'd4, 8'd3, 1'b1, 1'b1, 1'b1, 1'b1, 8'd6,  1'b0},
    {1'b1, 8'd2, 8'd2, 1'b1, 1'b0, 1'b0, 1'b1, 8'd5,  1'b0},
    {1'b0, 8'd2, 8'd2, 1'b1, 1'b0, 1'b1, 1'b0, 8'd66, 1'b1},
    {1'b1, 8'd5, 8'd0, 1'b1, 1'b1, 1'b1, 1'b0, 8'd69, 1'b1},
    {1'b0, 8'd6, 8'd4, 1'b1, 1'b1, 1'b1, 1'b1, 8'd8,  1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_ready;
  logic [ADDR_W-1:0] req_addr = '0, mem_addr;
  logic [DATA_W-1:0] req_wdata = '0, mem_wdata, mem_rdata, rsp_rdata;
  logic [CNT_W-1:0] cfg_access = '0, cfg_turn = '0;
  logic cfg_rdy_en = 1'b0, cfg_rdy_pol = 1'b1, cfg_abort_en = 1'b0;
  logic mem_re_n, mem_we_n, mem_rdy = 1'b0, rsp_valid, rsp_err;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign mem_rdata = mem_addr ^ 16'h5A5A;

  amseq_top dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .cfg_access(cfg_access), .cfg_turn(cfg_turn), .cfg_rdy_en(cfg_rdy_en),
    .cfg_rdy_pol(cfg_rdy_pol), .cfg_abort_en(cfg_abort_en),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_re_n(mem_re_n), .mem_we_n(mem_we_n), .mem_rdy(mem_rdy),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata));

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic bit strobe_low(input bit wr);
    return wr ? !mem_we_n : !mem_re_n;
  endfunction

  // accept one request; returns at the first negedge with strobe low
  task automatic issue(input bit wr, input logic [15:0] a, input logic [15:0] d);
    while (!req_ready) @(negedge clk);
    req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (10000) @(negedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    if (!done) finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(mem_re_n && mem_we_n, "R1 strobes high", {mem_re_n, mem_we_n}, 3);
    check(req_ready, "R1 req_ready", req_ready, 1);
    check(!rsp_valid, "R1 rsp_valid", rsp_valid, 0);

    for (int i = 0; i < NVEC; i++) begin
      logic [29:0] v;
      bit wr, act, eerr;
      int elow, lo, t;
      logic [15:0] a, d;
      v = VEC[i];
      wr = v[29]; cfg_access = v[28:21]; cfg_turn = v[20:13];
      cfg_rdy_en = v[12]; cfg_rdy_pol = v[11]; cfg_abort_en = v[10];
      act = v[9]; elow = int'(v[8:1]); eerr = v[0];
      mem_rdy = act ? cfg_rdy_pol : !cfg_rdy_pol;
      a = 16'h0100 + 16'(i); d = 16'hA000 + 16'(i);
      repeat (3) @(negedge clk);
      issue(wr, a, d);
      // R2 correct strobe and held pins
      check(strobe_low(wr) && (wr ? mem_re_n : mem_we_n), "R2 strobe select", i, i);
      check(mem_addr == a, "R2 address held", mem_addr, a);
      if (wr) check(mem_wdata == d, "R2 write data held", mem_wdata, d);
      lo = 0;
      while (strobe_low(wr) && lo < 300) begin
        lo++;
        @(negedge clk);
      end
      // R3 R4 R5 R6 R7 strobe length
      check(lo == elow, "R3/R4/R5/R6/R7 strobe length", lo, elow);
      // R11 one pulse following the strobe
      check(rsp_valid, "R11 response pulse", rsp_valid, 1);
      check(rsp_err == eerr, "R7 error flag", rsp_err, eerr);
      if (!wr) check(rsp_rdata == (a ^ 16'h5A5A), "R10 read data", rsp_rdata, a ^ 16'h5A5A);
      t = 0;
      while (!req_ready && t < 300) begin
        t++;
        @(negedge clk);
        if (t == 1) check(!rsp_valid, "R11 single pulse", rsp_valid, 0);
      end
      // R9 turnaround gap
      check(t == int'(cfg_turn), "R9 turnaround", t, cfg_turn);
    end

    // R4 late ready on a read: release within 5 cycles of the pin change
    begin
      int k;
      cfg_access = 8'd2; cfg_turn = 8'd0; cfg_rdy_en = 1'b1; cfg_rdy_pol = 1'b1;
      cfg_abort_en = 1'b1; mem_rdy = 1'b0;
      repeat (3) @(negedge clk);
      issue(1'b0, 16'h0777, 16'h0);
      repeat (10) @(negedge clk);
      check(!mem_re_n, "R4 still waiting", mem_re_n, 0);
      mem_rdy = 1'b1;
      k = 0;
      while (!mem_re_n && k < 20) begin
        k++;
        @(negedge clk);
      end
      check(k <= 5 && k >= 1, "R4 read release bound", k, 5);
      check(rsp_valid && !rsp_err, "R4 clean finish", rsp_err, 0);
      check(rsp_rdata == (16'h0777 ^ 16'h5A5A), "R10 late read data", rsp_rdata,
            16'h0777 ^ 16'h5A5A);
    end

    // R5 late ready on a write: two cycles after the synchronized ready
    begin
      int k;
      cfg_access = 8'd1; cfg_turn = 8'd0; cfg_rdy_en = 1'b1; cfg_rdy_pol = 1'b0;
      cfg_abort_en = 1'b0; mem_rdy = 1'b1;
      repeat (3) @(negedge clk);
      issue(1'b1, 16'h0888, 16'h1234);
      repeat (6) @(negedge clk);
      mem_rdy = 1'b0;
      k = 0;
      while (!mem_we_n && k < 20) begin
        k++;
        @(negedge clk);
      end
      check(k == 5, "R5 write release timing", k, 5);
    end

    // R8 no abort: waits well past 64 cycles
    begin
      int k;
      cfg_access = 8'd1; cfg_turn = 8'd1; cfg_rdy_en = 1'b1; cfg_rdy_pol = 1'b1;
      cfg_abort_en = 1'b0; mem_rdy = 1'b0;
      repeat (3) @(negedge clk);
      issue(1'b0, 16'h0999, 16'h0);
      repeat (120) @(negedge clk);
      check(!mem_re_n, "R8 still waiting past 64", mem_re_n, 0);
      check(!rsp_valid, "R8 no early response", rsp_valid, 0);
      mem_rdy = 1'b1;
      k = 0;
      while (!mem_re_n && k < 20) begin
        k++;
        @(negedge clk);
      end
      check(rsp_valid && !rsp_err, "R8 finish without error", rsp_err, 0);
    end

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule